// File: doc/BRIEF.md
# Keyed Service Watchdog Timer

This block is a watchdog down-counter that runs on a slow, low-power clock. Software keeps it from expiring by writing two 16-bit key values to a service register, one after the other. A completed pair reloads the counter from the timeout register. If the counter reaches its end before a completed pair arrives, the block asserts either a reset request or an interrupt request, depending on the configured action. In interrupt-first mode, a second expiry with no service in between turns into a reset request.

Software reaches the block through a small register bus. Each write is one cycle, with address, data and a write strobe. Reads are combinational on the address. There are three registers: control at address 0, timeout at address 1 and service at address 2. Other bus traffic may fall between the two key writes without disarming the sequence. The bus is assumed to run in the same clock domain as the counter.

Top module: `keyed_watchdog`

## Requirements
- R1: After a cycle with `rst_n` low, `irq` and `rst_req` are 0, control reads 0 and timeout reads `DEF_TIMEOUT`.
- R2: Writing 0xA602 in bits 15:0 to the service register (address 2) arms the sequence. A following service write of 0xB480 completes servicing and reloads the counter from the timeout register.
- R3: Reads, and writes to addresses other than 2, between the two key writes do not disarm the sequence.
- R4: Any service-register write other than 0xB480 while armed disarms the sequence. A 0xB480 write while not armed has no effect.
- R5: The counter counts only while enabled. With timeout T, expiry happens on the (T+1)th clock edge after the edge that enabled it or that completed a service.
- R6: Control bit 0 enables the watchdog and control bit 1 selects interrupt-first. With bit 1 at 0, an expiry sets `rst_req`.
- R7: With interrupt-first selected, an expiry while `irq` is low sets `irq`. Completed servicing clears `irq`. An expiry while `irq` is high sets `rst_req`.
- R8: Once set, `rst_req` stays at 1 until a cycle with `rst_n` low, whatever the bus does, including disabling the watchdog.
- R9: Writes to the timeout register are ignored while the watchdog is enabled and take effect while it is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow low-power clock for the counter and the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 2 | Register address: 0 control, 1 timeout, 2 service |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request on a first expiry in interrupt-first mode |
| rst_req | output | 1 | Sticky reset request |

## Verification
A behavioural reference model is compared with `irq` and `rst_req` on every clock. The main function is tried under five patterns:
- Running idle in each action mode gives the exact expiry edge and separates reset-only from escalation.
- Regular keyed service with unrelated writes and reads placed between the keys shows that interleaved traffic does not disarm the sequence.
- A wrong second key and a lone second key show that an incomplete pair never reloads the counter.
- A correct pair sent just before expiry moves the expiry edge.
- Timeout writes in the enabled and the disabled state separate the locked register from the open one.

// File: rtl/kwd_pkg.sv
// Package: shared constants and register decode for the keyed watchdog.
// Assumes a 2-bit register address space and 16-bit service keys.
package kwd_pkg;
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_ARM  = 16'hA602;
    localparam logic [KEY_W-1:0] KEY_DONE = 16'hB480;
    localparam int CTRL_EN_BIT        = 0;
    localparam int CTRL_IRQ_FIRST_BIT = 1;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TMO  = 2'd1,
        REG_SVC  = 2'd2,
        REG_NONE = 2'd3
    } kwd_reg_e;
endpackage

// File: rtl/kwd_regs.sv
// Module: control and timeout registers with combinational read mux.
// Assumes CNT_W <= DATA_W; the timeout is locked while the enable bit is set.
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int DEF_TIMEOUT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              en_q,
    output logic              irq_first_q,
    output logic [CNT_W-1:0]  tmo_q,
    output logic [DATA_W-1:0] rdata
);
    kwd_reg_e sel;
    assign sel = kwd_reg_e'(addr);

    // Control register: enable and action select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            irq_first_q <= 1'b0;
        end else if (wr_en && sel == REG_CTRL) begin
            en_q        <= wdata[CTRL_EN_BIT];
            irq_first_q <= wdata[CTRL_IRQ_FIRST_BIT];
        end
    end

    // Timeout register: accepts writes only while the watchdog is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= CNT_W'(DEF_TIMEOUT);
        end else if (wr_en && sel == REG_TMO && !en_q) begin
            tmo_q <= wdata[CNT_W-1:0];
        end
    end

    // Read mux: selected register, zero-extended.
    always_comb begin
        rdata = '0;
        case (sel)
            REG_CTRL: begin
                rdata[CTRL_EN_BIT]        = en_q;
                rdata[CTRL_IRQ_FIRST_BIT] = irq_first_q;
            end
            REG_TMO:  rdata[CNT_W-1:0] = tmo_q;
            default:  rdata = '0;
        endcase
    end

    // R9: an enabled watchdog keeps its timeout across any bus write.
    a_r9_tmo_locked: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(tmo_q));
endmodule

// File: rtl/kwd_key_seq.sv
// Module: two-key service sequence checker.
// Assumes only writes to the service address affect the armed state.
module kwd_key_seq
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [KEY_W-1:0] key,
    output logic             svc_pulse
);
    logic     armed_q;
    logic     svc_wr;
    kwd_reg_e sel;

    assign sel       = kwd_reg_e'(addr);
    assign svc_wr    = wr_en && (sel == REG_SVC);
    assign svc_pulse = svc_wr && armed_q && (key == KEY_DONE);

    // Armed flag: set by the first key, cleared by any other service write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (svc_wr) begin
            armed_q <= (key == KEY_ARM);
        end
    end

    // R2: the first key always leaves the sequence armed.
    a_r2_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && key == KEY_ARM) |=> armed_q);
    // R4: a completed pair leaves the sequence disarmed.
    a_r4_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pulse |=> !armed_q);
endmodule

// File: rtl/kwd_counter.sv
// Module: timeout down-counter with expiry strobe.
// Assumes the counter holds the timeout while disabled and reloads on service or expiry.
module kwd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             svc,
    input  logic [CNT_W-1:0] tmo,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = en && !svc && (cnt_q == '0);

    // Count register: load when idle, on service or on expiry, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || svc || expire) begin
            cnt_q <= tmo;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R5: an enabled, unserviced count steps down by one per clock.
    a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !svc && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R2: servicing reloads the counter from the timeout.
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (en && svc) |=> (cnt_q == $past(tmo)));
endmodule

// File: rtl/kwd_action.sv
// Module: expiry action with interrupt-first escalation and sticky reset request.
// Assumes an expiry strobe never coincides with a service strobe.
module kwd_action (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic svc,
    input  logic irq_first,
    output logic irq_q,
    output logic rst_req_q
);
    // Interrupt request: raised on a first expiry, cleared by service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (svc) begin
            irq_q <= 1'b0;
        end else if (expire && irq_first) begin
            irq_q <= 1'b1;
        end
    end

    // Reset request: set on a reset-mode or escalated expiry, held until rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
        end else if (expire && (!irq_first || irq_q)) begin
            rst_req_q <= 1'b1;
        end
    end

    // R8: the reset request never drops without rst_n.
    a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |=> rst_req_q);
    // R7: an expiry with a pending interrupt escalates.
    a_r7_escalate: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_q) |=> rst_req_q);
    // R7: servicing clears the interrupt request.
    a_r7_svc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> !irq_q);
endmodule

// File: rtl/keyed_watchdog.sv
// Module: keyed-service watchdog top.
// Assumes bus and counter share the slow clock.
// Wires the register file, key checker, counter and expiry action together.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 32,
    parameter int DEF_TIMEOUT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    logic             en_q;
    logic             irq_first_q;
    logic [CNT_W-1:0] tmo_q;
    logic             svc_pulse;
    logic             expire;

    kwd_regs #(
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .DEF_TIMEOUT (DEF_TIMEOUT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .en_q        (en_q),
        .irq_first_q (irq_first_q),
        .tmo_q       (tmo_q),
        .rdata       (rdata)
    );

    kwd_key_seq u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .key       (wdata[KEY_W-1:0]),
        .svc_pulse (svc_pulse)
    );

    kwd_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_q),
        .svc    (svc_pulse),
        .tmo    (tmo_q),
        .expire (expire)
    );

    kwd_action u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .svc       (svc_pulse),
        .irq_first (irq_first_q),
        .irq_q     (irq),
        .rst_req_q (rst_req)
    );

    // R6: a reset request only appears while the watchdog is enabled or already set.
    a_r6_rst_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(en_q));
endmodule

// File: tb/keyed_watchdog_tb.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module keyed_watchdog_tb;
    localparam int DW  = 32;
    localparam int DEF = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd3;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, rst_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state
    bit  m_en, m_act, m_armed, m_irq, m_rst;
    longint m_tmo, m_cnt;

    keyed_watchdog #(.DATA_W(DW), .CNT_W(32), .DEF_TIMEOUT(DEF)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances on each edge from the inputs and its old state.
    always @(posedge clk) begin
        bit svc, exp_ev, svc_wr;
        bit n_en, n_act, n_armed, n_irq, n_rst;
        longint n_tmo, n_cnt;
        if (!rst_n) begin
            m_en = 0; m_act = 0; m_armed = 0; m_irq = 0; m_rst = 0;
            m_tmo = DEF; m_cnt = 0;
        end else begin
            svc_wr = wr_en && addr == 2'd2;
            svc    = svc_wr && m_armed && wdata[15:0] == 16'hB480;
            exp_ev = m_en && !svc && m_cnt == 0;
            n_en = m_en; n_act = m_act; n_tmo = m_tmo; n_irq = m_irq; n_rst = m_rst;
            n_armed = svc_wr ? (wdata[15:0] == 16'hA602) : m_armed;
            n_cnt = (!m_en || svc || exp_ev) ? m_tmo : m_cnt - 1;
            if (exp_ev) begin
                if (!m_act || m_irq) n_rst = 1; else n_irq = 1;
            end
            if (svc) n_irq = 0;
            if (wr_en && addr == 2'd0) begin n_en = wdata[0]; n_act = wdata[1]; end
            if (wr_en && addr == 2'd1 && !m_en) n_tmo = wdata;
            m_en = n_en; m_act = n_act; m_tmo = n_tmo; m_cnt = n_cnt;
            m_armed = n_armed; m_irq = n_irq; m_rst = n_rst;
        end
    end

    // Every-clock comparison of the request outputs (R5, R6, R7, R8).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(irq == m_irq, "R7 irq vs model", irq, m_irq);
            check(rst_req == m_rst, "R6 rst_req vs model", rst_req, m_rst);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 2'd3; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input longint exp, input string tag);
        @(negedge clk); #1;
        addr = a; #1;
        check(rdata == exp, tag, rdata, exp);
        addr = 2'd3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(2);
        do_reset();
        // R1: reset state
        check(irq == 0, "R1 irq after reset", irq, 0);
        check(rst_req == 0, "R1 rst_req after reset", rst_req, 0);
        rd(2'd0, 0, "R1 control after reset");
        rd(2'd1, DEF, "R1 timeout after reset");

        // R5/R6: reset action, exact expiry edge
        wr(2'd1, 5);
        rd(2'd1, 5, "R9 timeout written while disabled");
        wr(2'd0, 1);
        idle(5);
        check(rst_req == 0, "R5 no early expiry", rst_req, 0);
        idle(1);
        check(rst_req == 1, "R6 reset on expiry", rst_req, 1);
        idle(3);
        wr(2'd0, 0);
        idle(2);
        check(rst_req == 1, "R8 rst_req held after disable", rst_req, 1);
        do_reset();
        check(rst_req == 0, "R8 rst_req cleared by rst_n", rst_req, 0);

        // R5: disabled watchdog never expires
        wr(2'd1, 2);
        idle(12);
        check(rst_req == 0 && irq == 0, "R5 no counting while disabled", rst_req, 0);

        // R3/R9: interleaved traffic between keys, interrupt-first mode
        wr(2'd1, 12);
        wr(2'd0, 3);
        for (int i = 0; i < 5; i++) begin
            wr(2'd2, 32'h0000A602);
            wr(2'd1, 32'd77);
            rd(2'd0, 3, "R3 control read between keys");
            wr(2'd0, 3);
            wr(2'd2, 32'h0000B480);
            idle(3);
        end
        check(irq == 0, "R3 service survives interleaved traffic", irq, 0);
        rd(2'd1, 12, "R9 timeout write ignored while enabled");

        // R4: wrong second key disarms; later KEY2 does nothing
        wr(2'd2, 32'h0000A602);
        wr(2'd2, 32'h00001234);
        wr(2'd2, 32'h0000B480);
        idle(10);
        check(irq == 1, "R4 broken sequence does not service", irq, 1);
        check(rst_req == 0, "R7 first expiry gives irq only", rst_req, 0);

        // R7: service clears irq, then escalation
        wr(2'd2, 32'h0000A602);
        wr(2'd2, 32'h0000B480);
        check(irq == 0, "R7 service clears irq", irq, 0);
        idle(14);
        check(irq == 1 && rst_req == 0, "R7 irq again after service", irq, 1);
        idle(13);
        check(rst_req == 1, "R7 second expiry escalates", rst_req, 1);

        // R4: lone KEY2 without arming has no effect
        do_reset();
        wr(2'd1, 4);
        wr(2'd0, 1);
        wr(2'd2, 32'h0000B480);
        idle(3);
        check(rst_req == 0, "R4 before expiry", rst_req, 0);
        idle(1);
        check(rst_req == 1, "R4 lone KEY2 ignored", rst_req, 1);

        // R2: a completed pair moves the expiry edge
        do_reset();
        wr(2'd1, 4);
        wr(2'd0, 1);
        wr(2'd2, 32'h0000A602);
        wr(2'd2, 32'h0000B480);
        idle(4);
        check(rst_req == 0, "R2 service reloaded counter", rst_req, 0);
        idle(1);
        check(rst_req == 1, "R2 expiry after reload", rst_req, 1);

        idle(2);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule